// File: doc/BRIEF.md
# Strobed GPIO Port Bank

This peripheral sits beside a small 8-bit microcontroller core and provides three 8-bit ports, A, B and C. Each port has a direction register and an output register. Both are loaded from the core's write data bus by decoded per-port strobes. Ports A and B read their pin input vectors directly. Port C reads from a four-entry receive FIFO, which external logic fills through a valid/ready stream interface.

The read data bus is selected only by the low three bits of the file address. A separate per-port read strobe exists only to pop the FIFO. A read-modify-write instruction asserts the write strobe without the read strobe. It therefore sees the correct input value and never consumes the FIFO head.

The core's clock enable gates every strobe. The FIFO push side runs on every clock edge.

Receive stream rules:
- `rx_ready` is high whenever the FIFO holds fewer than four entries.
- A transfer happens on a clock edge where `rx_valid` and `rx_ready` are both high.
- Data offered while `rx_ready` is low is not held for a later edge. It is dropped, and the sticky `rx_ovf` flag is set.

Top module: `gpio_strobe_bank`

## Requirements
- R1: On a clock edge with `clk_en` high and `dir_wr[i]` high (i = 0, 1, 2 for ports A, B, C), the direction register of port i loads `wr_data`. A direction bit of 1 makes the pin an input, so its output-enable bit is 0. A direction bit of 0 drives the pin, so its output-enable bit is 1. Reset sets every direction bit to 1, so every `p*_oe` reads 0x00 after reset.
- R2: On a clock edge with `clk_en` high and `out_wr[i]` high, the output register of port i loads `wr_data`. `p*_out` always shows that register. Reset sets every output register to 0x00.
- R3: While `clk_en` is low, none of the following has any effect: `dir_wr`, `out_wr` and `rd_stb`. Registers and the FIFO head stay unchanged.
- R4: `rd_data` is combinational in `faddr` alone. When `faddr` is 3'b101 it equals `pa_in`, and when `faddr` is 3'b110 it equals `pb_in`. The value does not depend on `rd_stb` or `out_wr`.
- R5: When `faddr` is 3'b111, `rd_data` shows the FIFO head entry. For any `faddr` value from 3'b000 to 3'b100, `rd_data` is 0x00.
- R6: The FIFO pops only on an edge where `clk_en` and `rd_stb[2]` are both high. A read-modify-write of address 3'b111 asserts `out_wr[2]` without `rd_stb[2]`. Such an access leaves the head entry in place.
- R7: The FIFO holds 4 entries in first-in first-out order. `rx_ready` is low exactly when all 4 entries are occupied.
- R8: When `rx_valid` is high while `rx_ready` is low, the data is dropped and `rx_ovf` becomes 1. Once set, `rx_ovf` stays 1 until reset.
- R9: A pop while the FIFO is empty changes nothing. In that case `rd_data` at address 3'b111 reads 0x00. A later push becomes the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Core clock enable qualifying all strobes |
| dir_wr | input | 3 | Direction-register write strobes, bit i for port i |
| out_wr | input | 3 | Output-register write strobes, bit i for port i |
| rd_stb | input | 3 | Read strobes; only bit 2 has an effect (FIFO pop) |
| faddr | input | 3 | Low bits of the file address selecting read data |
| wr_data | input | 8 | Write data bus |
| rd_data | output | 8 | Read data bus |
| pa_in | input | 8 | Port A pin input values |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin input values |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B output enables |
| pc_out | output | 8 | Port C output values |
| pc_oe | output | 8 | Port C output enables |
| rx_valid | input | 1 | Receive stream data valid |
| rx_data | input | 8 | Receive stream data |
| rx_ready | output | 1 | Receive FIFO can accept data |
| rx_ovf | output | 1 | Sticky overflow flag |

## Verification
The bench performs a read-modify-write of address 3'b111 and checks that the FIFO head survives it. A design that popped on the write strobe, or on address decode, would skip an entry.

The bench also checks the following cases:
- Strobes issued with `clk_en` low must leave the registers and the head unchanged. A design that ignored the enable would load or pop.
- A fifth push while full must be dropped, and the overflow flag must stay set after the FIFO drains. A design with a wrong full test would overwrite the oldest entry or lose the flag.
- A pop of an empty FIFO must leave the pointers alone, so that the next push reads back as the head. A design that moved the pointers would show stale data.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int NUM_PORTS = 3;
  localparam int SEL_W     = 3;
  localparam int IDX_A     = 0;
  localparam int IDX_B     = 1;
  localparam int IDX_C     = 2;
  localparam logic [SEL_W-1:0] SEL_A = 3'b101;
  localparam logic [SEL_W-1:0] SEL_B = 3'b110;
  localparam logic [SEL_W-1:0] SEL_C = 3'b111;
endpackage

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clk_en,
  input  logic         dir_we,
  input  logic         out_we,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  logic [W-1:0] dir_q;
  logic [W-1:0] out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '1;
      out_q <= '0;
    end else if (clk_en) begin
      if (dir_we) dir_q <= wr_data;
      if (out_we) out_q <= wr_data;
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;
endmodule

// File: rtl/gpio_rx_fifo.sv
module gpio_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  input  logic [W-1:0] push_data,
  output logic         push_ready,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          empty, do_push, do_pop;

  assign empty      = (count == '0);
  assign push_ready = (count != FULL);
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_valid && !push_ready) ovf <= 1'b1;
    end
  end

  assign head = empty ? '0 : mem[rptr];
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_bank_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  input  logic [W-1:0]     fifo_head,
  output logic [W-1:0]     rd_data
);
  always_comb begin
    case (sel)
      SEL_A:   rd_data = in_a;
      SEL_B:   rd_data = in_b;
      SEL_C:   rd_data = fifo_head;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gpio_strobe_bank.sv
module gpio_strobe_bank
  import gpio_bank_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clk_en,
  input  logic [NUM_PORTS-1:0] dir_wr,
  input  logic [NUM_PORTS-1:0] out_wr,
  input  logic [NUM_PORTS-1:0] rd_stb,
  input  logic [SEL_W-1:0]     faddr,
  input  logic [W-1:0]         wr_data,
  output logic [W-1:0]         rd_data,
  input  logic [W-1:0]         pa_in,
  output logic [W-1:0]         pa_out,
  output logic [W-1:0]         pa_oe,
  input  logic [W-1:0]         pb_in,
  output logic [W-1:0]         pb_out,
  output logic [W-1:0]         pb_oe,
  output logic [W-1:0]         pc_out,
  output logic [W-1:0]         pc_oe,
  input  logic                 rx_valid,
  input  logic [W-1:0]         rx_data,
  output logic                 rx_ready,
  output logic                 rx_ovf
);
  logic [W-1:0] drv [NUM_PORTS];
  logic [W-1:0] oen [NUM_PORTS];
  logic [W-1:0] head;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    gpio_port #(.W(W)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .clk_en  (clk_en),
      .dir_we  (dir_wr[p]),
      .out_we  (out_wr[p]),
      .wr_data (wr_data),
      .pin_out (drv[p]),
      .pin_oe  (oen[p])
    );
  end

  assign pa_out = drv[IDX_A];
  assign pa_oe  = oen[IDX_A];
  assign pb_out = drv[IDX_B];
  assign pb_oe  = oen[IDX_B];
  assign pc_out = drv[IDX_C];
  assign pc_oe  = oen[IDX_C];

  gpio_rx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (rx_valid),
    .push_data  (rx_data),
    .push_ready (rx_ready),
    .pop        (clk_en && rd_stb[IDX_C]),
    .head       (head),
    .ovf        (rx_ovf)
  );

  gpio_rd_mux #(.W(W)) u_mux (
    .sel       (faddr),
    .in_a      (pa_in),
    .in_b      (pb_in),
    .fifo_head (head),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/gpio_strobe_bank_chk.sv
module gpio_strobe_bank_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clk_en,
  input logic [2:0]   dir_wr,
  input logic [2:0]   out_wr,
  input logic [2:0]   rd_stb,
  input logic [2:0]   faddr,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] rd_data,
  input logic [W-1:0] pa_in,
  input logic [W-1:0] pa_out,
  input logic [W-1:0] pa_oe,
  input logic [W-1:0] pb_out,
  input logic [W-1:0] pb_oe,
  input logic [W-1:0] pc_out,
  input logic [W-1:0] pc_oe,
  input logic         rx_valid,
  input logic         rx_ready,
  input logic         rx_ovf
);
  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && dir_wr[0] |=> pa_oe == ~$past(wr_data)); // R1
  AST_OUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && out_wr[1] |=> pb_out == $past(wr_data)); // R2
  AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(pa_out) && $stable(pa_oe) && $stable(pb_out)
                && $stable(pb_oe) && $stable(pc_out) && $stable(pc_oe)); // R3
  AST_PIN_MUX: assert property (@(posedge clk) disable iff (!rst_n)
    faddr == 3'b101 |-> rd_data == pa_in); // R4
  AST_HEAD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    faddr == 3'b111 && !(clk_en && rd_stb[2]) && !rx_valid
      |=> faddr != 3'b111 || $stable(rd_data)); // R6
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_ovf); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |=> rx_ovf); // R8
endmodule

bind gpio_strobe_bank gpio_strobe_bank_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .dir_wr(dir_wr),
  .out_wr(out_wr), .rd_stb(rd_stb), .faddr(faddr), .wr_data(wr_data),
  .rd_data(rd_data), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
  .pb_out(pb_out), .pb_oe(pb_oe), .pc_out(pc_out), .pc_oe(pc_oe),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_ovf(rx_ovf)
);

// File: tb/tb_gpio_strobe_bank.sv
`timescale 1ns/1ps
module tb_gpio_strobe_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b1;
  logic [2:0] dir_wr = '0, out_wr = '0, rd_stb = '0, faddr = '0;
  logic [7:0] wr_data = '0, pa_in = '0, pb_in = '0, rx_data = '0;
  logic       rx_valid = 1'b0;
  logic [7:0] rd_data, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic       rx_ready, rx_ovf;
  int         n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  gpio_strobe_bank dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .dir_wr(dir_wr),
    .out_wr(out_wr), .rd_stb(rd_stb), .faddr(faddr), .wr_data(wr_data),
    .rd_data(rd_data), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_out(pc_out),
    .pc_oe(pc_oe), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .rx_ovf(rx_ovf)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one-cycle strobe: applied at a falling edge, removed at the next
  task automatic strobe(input logic [2:0] dw, input logic [2:0] ow,
                        input logic [2:0] rs, input logic [7:0] d, input logic ce);
    @(negedge clk);
    dir_wr = dw; out_wr = ow; rd_stb = rs; wr_data = d; clk_en = ce;
    @(negedge clk);
    dir_wr = '0; out_wr = '0; rd_stb = '0; clk_en = 1'b1;
    #1;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
    #1;
  endtask

  task automatic pop();
    strobe(3'b000, 3'b000, 3'b100, 8'h00, 1'b1);
  endtask

  task automatic t_reset();
    faddr = 3'b111; #1;
    chk("R1 reset pa_oe", pa_oe, 8'h00);
    chk("R1 reset pc_oe", pc_oe, 8'h00);
    chk("R2 reset pa_out", pa_out, 8'h00);
    chk("R7 reset rx_ready", {7'd0, rx_ready}, 8'h01);
    chk("R8 reset rx_ovf", {7'd0, rx_ovf}, 8'h00);
    chk("R9 reset empty head", rd_data, 8'h00);
  endtask

  task automatic t_dir();
    strobe(3'b001, 3'b000, 3'b000, 8'h0F, 1'b1);
    chk("R1 pa_oe", pa_oe, 8'hF0);
    strobe(3'b010, 3'b000, 3'b000, 8'hAA, 1'b1);
    chk("R1 pb_oe", pb_oe, 8'h55);
    chk("R1 pa_oe untouched", pa_oe, 8'hF0);
    strobe(3'b100, 3'b000, 3'b000, 8'h00, 1'b1);
    chk("R1 pc_oe", pc_oe, 8'hFF);
  endtask

  task automatic t_out();
    strobe(3'b000, 3'b001, 3'b000, 8'h5A, 1'b1);
    chk("R2 pa_out", pa_out, 8'h5A);
    strobe(3'b000, 3'b010, 3'b000, 8'hC3, 1'b1);
    chk("R2 pb_out", pb_out, 8'hC3);
    chk("R2 pa_out untouched", pa_out, 8'h5A);
  endtask

  task automatic t_no_ce();
    strobe(3'b010, 3'b010, 3'b000, 8'h00, 1'b0);
    chk("R3 pb_oe held", pb_oe, 8'h55);
    chk("R3 pb_out held", pb_out, 8'hC3);
  endtask

  task automatic t_mux();
    pa_in = 8'h96; pb_in = 8'h3E;
    faddr = 3'b101; rd_stb = 3'b001; #1;
    chk("R4 addr5 with strobe", rd_data, 8'h96);
    rd_stb = 3'b000; #1;
    chk("R4 addr5 no strobe", rd_data, 8'h96);
    faddr = 3'b110; #1;
    chk("R4 addr6", rd_data, 8'h3E);
    faddr = 3'b000; #1;
    chk("R5 addr0", rd_data, 8'h00);
    faddr = 3'b100; #1;
    chk("R5 addr4", rd_data, 8'h00);
    faddr = 3'b111; #1;
  endtask

  task automatic t_fifo();
    push(8'h11); push(8'h22); push(8'h33);
    chk("R7 ready at 3", {7'd0, rx_ready}, 8'h01);
    push(8'h44);
    chk("R7 ready low when full", {7'd0, rx_ready}, 8'h00);
    chk("R5 head shown", rd_data, 8'h11);
    push(8'h55);
    chk("R8 overflow set", {7'd0, rx_ovf}, 8'h01);
    strobe(3'b000, 3'b100, 3'b000, 8'h99, 1'b1);
    chk("R6 rmw keeps head", rd_data, 8'h11);
    chk("R6 rmw wrote pc_out", pc_out, 8'h99);
    strobe(3'b000, 3'b000, 3'b100, 8'h00, 1'b0);
    chk("R3 pop gated by clk_en", rd_data, 8'h11);
    pop(); chk("R7 order 2", rd_data, 8'h22);
    chk("R7 ready after pop", {7'd0, rx_ready}, 8'h01);
    pop(); chk("R7 order 3", rd_data, 8'h33);
    pop(); chk("R8 dropped data absent", rd_data, 8'h44);
    pop(); chk("R9 empty reads zero", rd_data, 8'h00);
    chk("R8 overflow sticky", {7'd0, rx_ovf}, 8'h01);
  endtask

  task automatic t_empty_pop();
    pop(); pop();
    chk("R9 empty pop reads zero", rd_data, 8'h00);
    push(8'h77);
    chk("R9 push after empty pop", rd_data, 8'h77);
    pop();
    chk("R9 drained again", rd_data, 8'h00);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_dir();
    t_out();
    t_no_ce();
    t_mux();
    t_fifo();
    t_empty_pop();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule